// File: doc/BRIEF.md
# Set-Associative Cache Tag Lookup

This block holds the tag, valid and data state of a small set-associative cache that keeps one 32-bit word per block. A requester presents a byte address. The block splits that address into three fields. The two lowest bits are a byte offset and are ignored. The next eight bits select one of 256 sets. The upper 22 bits form the tag. All ways of the selected set are read, and their tags are compared against the request tag at the same time. One cycle later the block reports either a hit, with that way's word, or a miss.

A separate fill port installs a block after a miss has been served elsewhere. The block chooses the way itself. It reuses a way that already holds the same tag. Failing that, it takes the lowest-numbered empty way. When the set is full, it takes the way named by that set's round-robin pointer. A request can also be a write. On a hit, the stored word is updated in place. A write that misses allocates nothing.

Sets, ways, address width and data width are parameters. Setting the way count to one gives a direct-mapped cache.

Top module: `cache_tag_lookup`

## Requirements
- R1: The set index is the block number (byte address divided by 4) modulo 256, and the tag is the block number divided by 256; the two byte-offset bits do not affect the result.
- R2: While reset is asserted and afterwards until a fill occurs, every entry is invalid, so every lookup misses and all response outputs read 0 when idle.
- R3: rsp_valid_o is high in exactly the cycle after a cycle in which req_valid_i is high. When it is high, exactly one of rsp_hit_o and rsp_miss_o is high. When it is low, both are low.
- R4: A hit requires a way in the selected set that is both valid and holds the request tag. The response then carries that way's word on rsp_data_o and the way number on rsp_way_o.
- R5: When no valid way of the set matches, the response is a miss with rsp_data_o = 0 and rsp_way_o = 0.
- R6: A fill whose tag is already valid in its set overwrites that same way. Otherwise it goes to the lowest-numbered invalid way of the set.
- R7: A fill into a set with all ways valid and no tag match replaces the way named by that set's round-robin pointer. The pointer starts at way 0 after reset and advances by one, wrapping, after each such replacement.
- R8: A write request (req_write_i = 1) that hits stores req_wdata_i into the hit way, and its response returns the word held before the write. A write that misses changes no entry.
- R9: A request sees the contents as they were before any fill or write in the same cycle. When a write hit and a fill target the same entry in the same cycle, the fill's word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Lookup request strobe |
| req_write_i | input | 1 | Request is a write-through update |
| req_addr_i | input | 32 | Request byte address |
| req_wdata_i | input | 32 | Word stored when a write request hits |
| fill_valid_i | input | 1 | Fill strobe |
| fill_addr_i | input | 32 | Byte address of the block being installed |
| fill_data_i | input | 32 | Word installed by the fill |
| rsp_valid_o | output | 1 | Response present, one cycle after a request |
| rsp_hit_o | output | 1 | Response is a hit |
| rsp_miss_o | output | 1 | Response is a miss |
| rsp_way_o | output | 2 | Way that hit, 0 on a miss |
| rsp_data_o | output | 32 | Hit word, 0 on a miss |

## Verification
The hardest state to reach from the ports is a full set whose round-robin pointer has already wrapped. Reaching it takes four distinct fills, then several more fills with new tags, and only lookups can show which way was evicted. The stimulus fills one set with more tags than it has ways and then probes every tag. A random phase then draws from six tags spread over two sets, so evictions, refills of a present tag, and write hits that collide with fills all recur. A behavioural model tracks valid, tag, data and pointer per set and predicts every response.

// File: rtl/cache_lookup_pkg.sv
package cache_lookup_pkg;
  localparam int unsigned DEF_ADDR_W   = 32;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_SETS     = 256;
  localparam int unsigned DEF_WAYS     = 4;
  localparam int unsigned DEF_OFFSET_W = 2;

  typedef enum logic [1:0] {
    FILL_SAME  = 2'd0,
    FILL_FREE  = 2'd1,
    FILL_EVICT = 2'd2
  } fill_src_e;
endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFFSET_W = 2,
  parameter int unsigned INDEX_W  = 8,
  localparam int unsigned TAG_W   = ADDR_W - INDEX_W - OFFSET_W
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [INDEX_W-1:0] index_o,
  output logic [TAG_W-1:0]   tag_o
);
  // power-of-two set count: modulo and divide reduce to bit fields
  assign index_o = addr_i[OFFSET_W +: INDEX_W];
  assign tag_o   = addr_i[ADDR_W-1 -: TAG_W];

  logic unused_offset;
  assign unused_offset = ^addr_i[OFFSET_W-1:0];
endmodule

// File: rtl/cache_way_match.sv
module cache_way_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 22,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) way_o = way_o | WAY_W'(w);
    end
  end

  assign hit_o = |match;

  // fill placement must never leave two copies of a tag in one set
  a_r6_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel
  import cache_lookup_pkg::*;
#(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [WAYS-1:0]   valid_i,
  input  logic              same_i,
  input  logic [WAY_W-1:0]  same_way_i,
  input  logic [WAY_W-1:0]  rr_i,
  output logic [WAY_W-1:0]  way_o,
  output fill_src_e         src_o
);
  logic [WAY_W-1:0] free_way;
  logic             any_free;

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) free_way = WAY_W'(w);
    end
  end

  assign any_free = ~&valid_i;

  always_comb begin
    if (same_i) begin
      src_o = FILL_SAME;
      way_o = same_way_i;
    end else if (any_free) begin
      src_o = FILL_FREE;
      way_o = free_way;
    end else begin
      src_o = FILL_EVICT;
      way_o = rr_i;
    end
  end

  a_r7_evict_only_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && src_o == FILL_EVICT) |-> (&valid_i && !same_i));
  a_r6_free_target_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && src_o == FILL_FREE) |-> !valid_i[way_o]);
endmodule

// File: rtl/cache_set_store.sv
module cache_set_store #(
  parameter int unsigned SETS   = 256,
  parameter int unsigned WAYS   = 4,
  parameter int unsigned TAG_W  = 22,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [IDX_W-1:0]            rd_a_idx_i,
  output logic [WAYS-1:0]             rd_a_valid_o,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_a_tag_o,
  output logic [WAYS-1:0][DATA_W-1:0] rd_a_data_o,
  input  logic [IDX_W-1:0]            rd_b_idx_i,
  output logic [WAYS-1:0]             rd_b_valid_o,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_b_tag_o,
  output logic [WAY_W-1:0]            rd_b_rr_o,
  input  logic                        upd_en_i,
  input  logic [IDX_W-1:0]            upd_idx_i,
  input  logic [WAY_W-1:0]            upd_way_i,
  input  logic [DATA_W-1:0]           upd_data_i,
  input  logic                        fill_en_i,
  input  logic                        fill_evict_i,
  input  logic [IDX_W-1:0]            fill_idx_i,
  input  logic [WAY_W-1:0]            fill_way_i,
  input  logic [TAG_W-1:0]            fill_tag_i,
  input  logic [DATA_W-1:0]           fill_data_i
);
  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [TAG_W-1:0]          tag_q  [SETS][WAYS];
  logic [DATA_W-1:0]         data_q [SETS][WAYS];
  logic [WAY_W-1:0]          rr_q   [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (fill_en_i) valid_q[fill_idx_i][fill_way_i] <= 1'b1;
  end

  // fill is written last so it wins over a same-entry update
  always_ff @(posedge clk_i) begin
    if (upd_en_i) data_q[upd_idx_i][upd_way_i] <= upd_data_i;
    if (fill_en_i) begin
      tag_q[fill_idx_i][fill_way_i]  <= fill_tag_i;
      data_q[fill_idx_i][fill_way_i] <= fill_data_i;
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_rr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rr_q[s] <= '0;
      else if (fill_en_i && fill_evict_i && fill_idx_i == IDX_W'(s))
        rr_q[s] <= (rr_q[s] == WAY_W'(WAYS - 1)) ? '0 : rr_q[s] + 1'b1;
    end
  end

  assign rd_a_valid_o = valid_q[rd_a_idx_i];
  assign rd_b_valid_o = valid_q[rd_b_idx_i];
  assign rd_b_rr_o    = rr_q[rd_b_idx_i];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_a_tag_o[w]  = tag_q[rd_a_idx_i][w];
    assign rd_a_data_o[w] = data_q[rd_a_idx_i][w];
    assign rd_b_tag_o[w]  = tag_q[rd_b_idx_i][w];
  end

  a_r6_fill_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |=> valid_q[$past(fill_idx_i)][$past(fill_way_i)]);
endmodule

// File: rtl/cache_tag_lookup.sv
module cache_tag_lookup
  import cache_lookup_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned NUM_SETS = DEF_SETS,
  parameter int unsigned NUM_WAYS = DEF_WAYS,
  parameter int unsigned OFFSET_W = DEF_OFFSET_W,
  localparam int unsigned IDX_W   = $clog2(NUM_SETS),
  localparam int unsigned TAG_W   = ADDR_W - IDX_W - OFFSET_W,
  localparam int unsigned WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_miss_o,
  output logic [WAY_W-1:0]  rsp_way_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  logic [IDX_W-1:0] req_idx, fill_idx;
  logic [TAG_W-1:0] req_tag, fill_tag;

  logic [NUM_WAYS-1:0]             a_valid, b_valid;
  logic [NUM_WAYS-1:0][TAG_W-1:0]  a_tag, b_tag;
  logic [NUM_WAYS-1:0][DATA_W-1:0] a_data;
  logic [WAY_W-1:0]                b_rr;

  logic             req_hit, fill_same;
  logic [WAY_W-1:0] req_way, fill_same_way, fill_way;
  fill_src_e        fill_src;
  logic             upd_en;

  cache_addr_split #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .INDEX_W(IDX_W)) u_split_req (
    .addr_i(req_addr_i), .index_o(req_idx), .tag_o(req_tag));

  cache_addr_split #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .INDEX_W(IDX_W)) u_split_fill (
    .addr_i(fill_addr_i), .index_o(fill_idx), .tag_o(fill_tag));

  cache_set_store #(.SETS(NUM_SETS), .WAYS(NUM_WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .rd_a_idx_i(req_idx), .rd_a_valid_o(a_valid), .rd_a_tag_o(a_tag), .rd_a_data_o(a_data),
    .rd_b_idx_i(fill_idx), .rd_b_valid_o(b_valid), .rd_b_tag_o(b_tag), .rd_b_rr_o(b_rr),
    .upd_en_i(upd_en), .upd_idx_i(req_idx), .upd_way_i(req_way), .upd_data_i(req_wdata_i),
    .fill_en_i(fill_valid_i), .fill_evict_i(fill_src == FILL_EVICT),
    .fill_idx_i(fill_idx), .fill_way_i(fill_way), .fill_tag_i(fill_tag),
    .fill_data_i(fill_data_i));

  cache_way_match #(.WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_match_req (
    .clk_i, .rst_ni, .valid_i(a_valid), .tags_i(a_tag), .tag_i(req_tag),
    .hit_o(req_hit), .way_o(req_way));

  cache_way_match #(.WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_match_fill (
    .clk_i, .rst_ni, .valid_i(b_valid), .tags_i(b_tag), .tag_i(fill_tag),
    .hit_o(fill_same), .way_o(fill_same_way));

  cache_victim_sel #(.WAYS(NUM_WAYS)) u_victim (
    .clk_i, .rst_ni, .en_i(fill_valid_i), .valid_i(b_valid),
    .same_i(fill_same), .same_way_i(fill_same_way), .rr_i(b_rr),
    .way_o(fill_way), .src_o(fill_src));

  assign upd_en = req_valid_i && req_write_i && req_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_way_o   <= '0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= req_valid_i && req_hit;
      rsp_miss_o  <= req_valid_i && !req_hit;
      rsp_way_o   <= (req_valid_i && req_hit) ? req_way : '0;
      rsp_data_o  <= (req_valid_i && req_hit) ? a_data[req_way] : '0;
    end
  end

  a_r3_rsp_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r3_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !rsp_hit_o && !rsp_miss_o);
  a_r3_hit_xor_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_hit_o ^ rsp_miss_o));
  a_r5_miss_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o |-> (rsp_data_o == '0 && rsp_way_o == '0));
endmodule

// File: tb/cache_tag_lookup_tb.sv
module cache_tag_lookup_tb;
  localparam int SETS = 256;
  localparam int WAYS = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0, fill_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0, fill_addr_i = '0, fill_data_i = '0;
  logic        rsp_valid_o, rsp_hit_o, rsp_miss_o;
  logic [1:0]  rsp_way_o;
  logic [31:0] rsp_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_tag = "";

  bit          m_val  [SETS][WAYS];
  logic [31:0] m_tag  [SETS][WAYS];
  logic [31:0] m_data [SETS][WAYS];
  int          m_rr   [SETS];

  always #4ns clk = ~clk;

  cache_tag_lookup u_dut (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i,
    .fill_valid_i, .fill_addr_i, .fill_data_i,
    .rsp_valid_o, .rsp_hit_o, .rsp_miss_o, .rsp_way_o, .rsp_data_o);

  function automatic logic [31:0] mk(input int tag, input int set, input int off);
    logic [31:0] blk;
    blk = 32'(tag) * 32'(SETS) + 32'(set);
    return blk * 32'd4 + 32'(off);
  endfunction

  function automatic int set_of(input logic [31:0] a);
    return int'((a / 32'd4) % 32'(SETS));
  endfunction

  function automatic logic [31:0] tag_of(input logic [31:0] a);
    return (a / 32'd4) / 32'(SETS);
  endfunction

  function automatic int find(input int s, input logic [31:0] t);
    for (int w = 0; w < WAYS; w++) if (m_val[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic step(input bit rq, input bit wr, input logic [31:0] ra, input logic [31:0] wd,
                      input bit fl, input logic [31:0] fa, input logic [31:0] fd);
    int rs, hw, fs, fw;
    logic [31:0] rt, ft, e_data;
    bit e_hit;
    string t;
    req_valid_i = rq; req_write_i = wr; req_addr_i = ra; req_wdata_i = wd;
    fill_valid_i = fl; fill_addr_i = fa; fill_data_i = fd;
    rs = set_of(ra); rt = tag_of(ra);
    hw = rq ? find(rs, rt) : -1;
    e_hit = (hw >= 0);
    e_data = e_hit ? m_data[rs][hw] : 32'd0;
    @(posedge clk);
    if (rq && wr && e_hit) m_data[rs][hw] = wd;
    if (fl) begin
      fs = set_of(fa); ft = tag_of(fa);
      fw = find(fs, ft);
      if (fw < 0) for (int w = WAYS - 1; w >= 0; w--) if (!m_val[fs][w]) fw = w;
      if (fw < 0) begin
        fw = m_rr[fs];
        m_rr[fs] = (m_rr[fs] + 1) % WAYS;
      end
      m_val[fs][fw] = 1; m_tag[fs][fw] = ft; m_data[fs][fw] = fd;
    end
    @(negedge clk);
    t = (cur_tag != "") ? cur_tag : (e_hit ? "R4" : "R5");
    chk("R3", "rsp_valid", 32'(rsp_valid_o), 32'(rq));
    chk(t, "rsp_hit", 32'(rsp_hit_o), 32'(rq && e_hit));
    chk(t, "rsp_miss", 32'(rsp_miss_o), 32'(rq && !e_hit));
    chk(t, "rsp_data", rsp_data_o, e_data);
    chk(t, "rsp_way", 32'(rsp_way_o), e_hit ? 32'(hw) : 32'd0);
  endtask

  task automatic rd(input logic [31:0] a);
    step(1, 0, a, 0, 0, 0, 0);
  endtask

  task automatic fill(input logic [31:0] a, input logic [31:0] d);
    step(0, 0, 0, 0, 1, a, d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin m_val[s][w] = 0; m_tag[s][w] = 0; m_data[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    cur_tag = "R2";
    chk("R2", "reset rsp_valid", 32'(rsp_valid_o), 0);
    chk("R2", "reset rsp_data", rsp_data_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R2", "idle rsp_hit", 32'(rsp_hit_o), 0);
    rd(mk(0, 0, 0)); rd(mk(5, 7, 2)); rd(mk(12345, 255, 3));

    // R1: offset ignored, set/tag from block number
    cur_tag = "R1";
    fill(mk(32'h155, 7, 0), 32'hA1A1_0001);
    rd(mk(32'h155, 7, 3));
    rd(mk(32'h155, 7, 1));
    rd(mk(32'h156, 7, 0));
    rd(mk(32'h155, 8, 0));

    // R6: empty ways filled lowest first, present tag reuses its way
    cur_tag = "R6";
    for (int i = 1; i <= 4; i++) fill(mk(i, 20, 0), 32'h600 + 32'(i));
    for (int i = 1; i <= 4; i++) rd(mk(i, 20, 0));
    fill(mk(3, 20, 1), 32'h6333);
    rd(mk(3, 20, 0));
    rd(mk(4, 20, 0));

    // R7: round-robin eviction with wrap
    cur_tag = "R7";
    for (int i = 5; i <= 9; i++) fill(mk(i, 20, 0), 32'h700 + 32'(i));
    for (int i = 1; i <= 9; i++) rd(mk(i, 20, 0));

    // R8: write-through on hit, no allocation on miss
    cur_tag = "R8";
    step(1, 1, mk(9, 20, 0), 32'hBEEF_0009, 0, 0, 0);
    rd(mk(9, 20, 0));
    step(1, 1, mk(100, 20, 0), 32'hDEAD_0100, 0, 0, 0);
    rd(mk(100, 20, 0));
    for (int i = 6; i <= 9; i++) rd(mk(i, 20, 0));

    // R9: same-cycle ordering
    cur_tag = "R9";
    step(1, 0, mk(2, 30, 0), 0, 1, mk(2, 30, 0), 32'h9000_0002);
    rd(mk(2, 30, 0));
    step(1, 1, mk(2, 30, 0), 32'h1111_1111, 1, mk(2, 30, 0), 32'h2222_2222);
    rd(mk(2, 30, 0));

    // R3: back-to-back and gapped requests
    cur_tag = "R3";
    rd(mk(2, 30, 0)); rd(mk(3, 30, 0)); rd(mk(2, 30, 1));
    step(0, 0, 0, 0, 0, 0, 0);
    rd(mk(7, 20, 0));
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);

    // random mix over two sets, six tags
    cur_tag = "";
    for (int n = 0; n < 3000; n++) begin
      int s1, s2;
      s1 = ($urandom % 2) ? 3 : 200;
      s2 = ($urandom % 2) ? 3 : 200;
      step(($urandom % 4) != 0, ($urandom % 3) == 0, mk(int'($urandom % 6) + 40, s1, int'($urandom % 4)),
           $urandom, ($urandom % 3) == 0, mk(int'($urandom % 6) + 40, s2, int'($urandom % 4)), $urandom);
    end
    step(0, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule